// File: doc/BRIEF.md
# Branch Map Checkpoint Store

This block keeps a saved copy of the speculative register rename map for every branch that is still unresolved. When a branch is dispatched, the map table presents its current contents. The store captures them in a free checkpoint slot and hands back that slot number as the branch's checkpoint ID. The captured copy is the map as it stands once the branch itself has been renamed.

When the branch resolves, the execution side returns the ID together with a mispredict flag. A correct resolution releases that one slot. A mispredict has two effects on the following cycle. First, the saved map is driven out so the map table can reload it at once, without waiting for the branch to retire. Second, a mask is driven out naming the mispredicted checkpoint and every checkpoint dispatched after it. All of those slots are released, and the mask tells downstream logic which branch tags to squash.

Age is tracked by dispatch order, not by slot number, so a slot that is reused becomes the youngest entry. Free-list repair and reorder buffer tail rollback are left to the surrounding logic.

Top module: `branch_ckpt_store`

## Requirements
- R1: After reset every slot is free: `disp_ready` is 1, `disp_id` is 0, `restore_valid` is 0 and `squash_mask` is 0.
- R2: `disp_id` always shows the lowest-numbered free slot (0 when none is free). A dispatch with `disp_valid` and `disp_ready` both high stores `disp_map` into that slot and makes the slot live.
- R3: `disp_ready` is low while all `NUM_CKPT` slots are live, and a dispatch request in that state stores nothing.
- R4: A mispredict resolve (`res_valid`=1, `res_mispredict`=1) of a live ID makes `restore_valid` 1 on the next cycle, with `restore_map` equal to the map stored under that ID.
- R5: On that same next cycle, `squash_mask` has bit `res_id` set plus the bit of every live slot dispatched after it, and no other bits. All slots in the mask become free.
- R6: A correct resolve (`res_mispredict`=0) of a live ID frees only that slot. `restore_valid` stays 0 and all other slots stay live.
- R7: A resolve whose ID is not live changes no slot and produces no restore.
- R8: While a mispredict resolve is presented, `disp_ready` is low, so a dispatch in the same cycle is dropped in favour of the restore.
- R9: When `restore_valid` is 0, `squash_mask` is 0. A restore lasts one cycle per mispredict.
- R10: Age follows dispatch order. A slot freed and then re-dispatched counts as younger than every slot still live, even ones with higher numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | A branch is dispatching and wants a checkpoint |
| disp_map | input | ARCH_REGS*PREG_W | Rename map contents after the branch is renamed |
| disp_ready | output | 1 | A checkpoint can be taken this cycle |
| disp_id | output | ID_W | Checkpoint ID given to the dispatching branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_id | input | ID_W | Checkpoint ID of the resolving branch |
| res_mispredict | input | 1 | 1 when the branch was mispredicted |
| restore_valid | output | 1 | Restore the map table from `restore_map` |
| restore_map | output | ARCH_REGS*PREG_W | Saved rename map of the mispredicted branch |
| squash_mask | output | NUM_CKPT | Checkpoint IDs discarded by this mispredict |

## Verification
The hardest case to reach is the one where age order and slot order disagree. A low-numbered slot has to be freed by a correct resolve and then re-allocated while higher-numbered slots are still live. A later mispredict of an older slot must then pull that low slot into the squash mask.

The stimulus table fills every slot and resolves a middle slot correctly. It then dispatches again into the freed slot and mispredicts a slot that was dispatched earlier. It also places a dispatch and a mispredict in the same cycle, and a correct resolve and a dispatch in the same cycle.

// File: rtl/branch_ckpt_store.sv
module branch_ckpt_store #(
  parameter int NUM_CKPT  = 4,
  parameter int ARCH_REGS = 8,
  parameter int PREG_W    = 6,
  localparam int ID_W  = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1,
  localparam int MAP_W = ARCH_REGS * PREG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [MAP_W-1:0] disp_map,
  output logic             disp_ready,
  output logic [ID_W-1:0]  disp_id,
  input  logic             res_valid,
  input  logic [ID_W-1:0]  res_id,
  input  logic             res_mispredict,
  output logic             restore_valid,
  output logic [MAP_W-1:0] restore_map,
  output logic [NUM_CKPT-1:0] squash_mask
);

  logic [MAP_W-1:0]    snap_q  [NUM_CKPT];
  logic [NUM_CKPT-1:0] older_q [NUM_CKPT];
  logic [NUM_CKPT-1:0] live_q;
  logic                restore_valid_q;
  logic [MAP_W-1:0]    restore_map_q;
  logic [NUM_CKPT-1:0] squash_q;

  logic [ID_W-1:0]     free_idx;
  logic                have_free;
  logic [NUM_CKPT-1:0] kill_mask, free_mask, alloc_mask;
  logic                res_live, kill_now, disp_fire;

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = NUM_CKPT - 1; i >= 0; i--) begin
      if (!live_q[i]) begin
        free_idx  = ID_W'(i);
        have_free = 1'b1;
      end
    end
  end

  assign res_live   = live_q[res_id];
  assign kill_now   = res_valid & res_mispredict & res_live;
  assign disp_ready = have_free & ~(res_valid & res_mispredict);
  assign disp_id    = free_idx;
  assign disp_fire  = disp_valid & disp_ready;
  assign alloc_mask = disp_fire ? (NUM_CKPT'(1) << free_idx) : '0;

  always_comb begin
    for (int j = 0; j < NUM_CKPT; j++)
      kill_mask[j] = live_q[j] & ((ID_W'(j) == res_id) | older_q[res_id][j]);
  end

  assign free_mask = kill_now ? kill_mask :
                     (res_valid & res_live) ? (NUM_CKPT'(1) << res_id) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q          <= '0;
      restore_valid_q <= 1'b0;
      restore_map_q   <= '0;
      squash_q        <= '0;
      for (int i = 0; i < NUM_CKPT; i++) older_q[i] <= '0;
    end else begin
      live_q          <= (live_q & ~free_mask) | alloc_mask;
      restore_valid_q <= kill_now;
      squash_q        <= kill_now ? kill_mask : '0;
      if (kill_now) restore_map_q <= snap_q[res_id];
      if (disp_fire) begin
        for (int j = 0; j < NUM_CKPT; j++) begin
          older_q[j][free_idx] <= live_q[j];
          older_q[free_idx][j] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (disp_fire) snap_q[free_idx] <= disp_map;
  end

  assign restore_valid = restore_valid_q;
  assign restore_map   = restore_map_q;
  assign squash_mask   = squash_q;

  assert_grant_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |-> !live_q[disp_id]);

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (&live_q) |-> !disp_ready);

  assert_restore_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> $past(res_valid && res_mispredict));

  assert_squash_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> squash_mask[$past(res_id)]);

  assert_squash_freed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> ((live_q & squash_mask) == '0));

  assert_ignore_dead_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !live_q[res_id] && !(disp_valid && disp_ready)) |=> (live_q == $past(live_q)));

  assert_restore_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_mispredict && live_q[res_id]) |=> ((live_q & ~$past(live_q)) == '0));

  assert_quiet_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_valid |-> (squash_mask == '0));

endmodule

// File: tb/branch_ckpt_store_tb.sv
module branch_ckpt_store_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int MW = 48;
  localparam int NV = 22;

  typedef struct packed {
    logic          dv;
    logic [MW-1:0] dmap;
    logic          rv;
    logic [1:0]    rid;
    logic          mp;
    logic          erdy;
    logic [1:0]    eid;
    logic          erv;
    logic [MW-1:0] emap;
    logic [NC-1:0] esq;
    logic [3:0]    req;
  } vec_t;

  localparam logic [MW-1:0] M0 = 48'h0A0A_0000_1111;
  localparam logic [MW-1:0] M1 = 48'h1B1B_0000_2222;
  localparam logic [MW-1:0] M2 = 48'h2C2C_0000_3333;
  localparam logic [MW-1:0] M3 = 48'h3D3D_0000_4444;
  localparam logic [MW-1:0] M4 = 48'h4E4E_0000_5555;
  localparam logic [MW-1:0] M5 = 48'h5F5F_0000_6666;
  localparam logic [MW-1:0] M6 = 48'h6060_0000_7777;
  localparam logic [MW-1:0] M7 = 48'h7171_0000_8888;
  localparam logic [MW-1:0] M8 = 48'h8282_0000_9999;
  localparam logic [MW-1:0] M9 = 48'h9393_0000_AAAA;
  localparam logic [MW-1:0] Z  = '0;

  localparam vec_t VECS [NV] = '{
    '{1'b1, M0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, Z,  4'b0000, 4'd2},  // R2 slot0
    '{1'b1, M1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, Z,  4'b0000, 4'd2},  // R2 slot1
    '{1'b1, M2, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, Z,  4'b0000, 4'd2},  // R2 slot2
    '{1'b1, M3, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, Z,  4'b0000, 4'd2},  // R2 slot3
    '{1'b1, M9, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, Z,  4'b0000, 4'd3},  // R3 full
    '{1'b0, Z,  1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 1'b0, Z,  4'b0000, 4'd6},  // R6 correct 2
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, Z,  4'b0000, 4'd6},  // R6 only 2 free
    '{1'b1, M4, 1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, Z,  4'b0000, 4'd10}, // R10 reuse 2
    '{1'b0, Z,  1'b1, 2'd3, 1'b1, 1'b0, 2'd0, 1'b1, M3, 4'b1100, 4'd10}, // R10 R5 R4
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, Z,  4'b0000, 4'd9},  // R9
    '{1'b0, Z,  1'b1, 2'd3, 1'b1, 1'b0, 2'd2, 1'b0, Z,  4'b0000, 4'd7},  // R7 dead id
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd2, 1'b0, Z,  4'b0000, 4'd7},  // R7 unchanged
    '{1'b1, M5, 1'b1, 2'd1, 1'b1, 1'b0, 2'd2, 1'b1, M1, 4'b0010, 4'd8},  // R8
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, Z,  4'b0000, 4'd8},  // R8 nothing stored
    '{1'b1, M6, 1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, Z,  4'b0000, 4'd6},  // R6 with dispatch
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, Z,  4'b0000, 4'd6},
    '{1'b0, Z,  1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 1'b1, M6, 4'b0010, 4'd4},  // R4
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, Z,  4'b0000, 4'd5},  // R5 all free
    '{1'b1, M7, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, Z,  4'b0000, 4'd2},
    '{1'b1, M8, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 1'b0, Z,  4'b0000, 4'd2},
    '{1'b0, Z,  1'b1, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1, M7, 4'b0011, 4'd5},  // R5 oldest
    '{1'b0, Z,  1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, Z,  4'b0000, 4'd9}   // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [MW-1:0] disp_map = '0;
  logic disp_ready;
  logic [1:0] disp_id;
  logic res_valid = 1'b0;
  logic [1:0] res_id = '0;
  logic res_mispredict = 1'b0;
  logic restore_valid;
  logic [MW-1:0] restore_map;
  logic [NC-1:0] squash_mask;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_ckpt_store #(.NUM_CKPT(NC), .ARCH_REGS(8), .PREG_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_map(disp_map),
    .disp_ready(disp_ready), .disp_id(disp_id),
    .res_valid(res_valid), .res_id(res_id), .res_mispredict(res_mispredict),
    .restore_valid(restore_valid), .restore_map(restore_map), .squash_mask(squash_mask)
  );

  task automatic check(input string what, input int req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input int req);
    check("disp_ready", req, MW'(disp_ready), MW'(1));
    check("disp_id", req, MW'(disp_id), MW'(0));
    check("restore_valid", req, MW'(restore_valid), MW'(0));
    check("squash_mask", req, MW'(squash_mask), MW'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1 check_idle(1);  // R1 during reset
    rst_n = 1'b1;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      disp_valid     = VECS[v].dv;
      disp_map       = VECS[v].dmap;
      res_valid      = VECS[v].rv;
      res_id         = VECS[v].rid;
      res_mispredict = VECS[v].mp;
      #1;
      check("disp_ready", int'(VECS[v].req), MW'(disp_ready), MW'(VECS[v].erdy));
      check("disp_id", int'(VECS[v].req), MW'(disp_id), MW'(VECS[v].eid));
      @(posedge clk);
      #2;
      check("restore_valid", int'(VECS[v].req), MW'(restore_valid), MW'(VECS[v].erv));
      check("squash_mask", int'(VECS[v].req), MW'(squash_mask), MW'(VECS[v].esq));
      if (VECS[v].erv)
        check("restore_map", int'(VECS[v].req), restore_map, VECS[v].emap);
    end

    // R1: reset in the middle of activity clears every slot
    @(negedge clk);
    disp_valid = 1'b1; disp_map = M2; res_valid = 1'b0; res_mispredict = 1'b0;
    repeat (2) @(negedge clk);
    disp_valid = 1'b0;
    #1 check("disp_id", 1, MW'(disp_id), MW'(2));
    res_valid = 1'b1; res_id = 2'd1; res_mispredict = 1'b1;
    @(negedge clk);
    res_valid = 1'b0; res_mispredict = 1'b0;
    rst_n = 1'b0;
    #1 check_idle(1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_idle(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule